// File: doc/BRIEF.md
# Binary Tree Elastic Router

This block is one node of a cycle-free binary-tree network. It has three bidirectional ports: a root-side port (index 0) and two child ports, left (index 1) and right (index 2). Each port carries an inbound and an outbound elastic channel. A channel has a data word, a valid flag that travels with the data, and a stall flag that travels back toward the sender. A word moves across a channel in any cycle where valid is high and stall is low. A packet is one word, and all of its routing information is in its upper address bits.

Each inbound channel has a steering stage. This stage reads the top address bit and picks one of the two other ports. It also builds the outgoing word by rotating the address field left by one place, so the next node finds its own decision bit at the top. Each outbound channel has a merge stage that arbitrates between its two possible sources in round-robin order. The winning word is held in a one-entry elastic half buffer. That buffer adds one cycle of latency per hop and can still pass a word in every cycle.

The merge stage has two state machines. The arbiter has the states FAVOR_A and FAVOR_B. When both sources request in a cycle where the buffer can accept, it moves to the state that favours the source that lost. The half buffer has the states EMPTY and FULL. It moves from EMPTY to FULL when a source is granted. It moves from FULL to EMPTY when the held word leaves and no new word is granted. It stays in FULL when a word leaves and a new word arrives in the same cycle.

Top module: `tree_router`

## Requirements
- R1: After reset every out_valid bit is 0, and every in_stall bit is 0 while its in_valid bit is 0.
- R2: A word that enters on the root port (0) with address bit W-1 equal to 1 leaves on the left port (1). With that bit equal to 0 it leaves on the right port (2).
- R3: A word that enters on a child port with address bit W-1 equal to 1 leaves on the root port (0). With that bit equal to 0 it leaves on the sibling child port (left to right, right to left).
- R4: The outgoing word has the A-bit address field in bits [W-1:W-A] rotated left by one place, so the old bit W-1 lands in bit W-A. Bits [W-A-1:0] are passed unchanged.
- R5: A word that is accepted at a clock edge appears on its output port, valid and complete, directly after that edge.
- R6: While an output has out_valid=1 and out_stall=1, its out_valid stays 1 and its out_data does not change at the next edge.
- R7: An input whose target output buffer is full and stalled asserts in_stall. Its word is delivered once the stall clears, and is neither lost nor duplicated.
- R8: When both sources of one output request in the same cycle, the lower-indexed source wins the first such contention after reset. The grant then alternates on every later contention.
- R9: An output whose out_stall is low passes a new word every cycle, with no bubble between back-to-back words.
- R10: Words from different inputs that target different outputs are accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 3 | Inbound valid per port (0 root, 1 left, 2 right) |
| in_data | input | 3 x W | Inbound word per port |
| in_stall | output | 3 | Stall back to each inbound sender |
| out_valid | output | 3 | Outbound valid per port |
| out_data | output | 3 x W | Outbound word per port |
| out_stall | input | 3 | Stall from each outbound receiver |

## Verification
The hardest case to reach is a flip of the arbiter pointer. Both sources of one output must request in the same cycle, and the buffer must be able to accept in that cycle. The first winner must then supply a fresh word immediately, so that contention is present again on the very next edge. The stimulus keeps both child ports valid toward the root port with out_stall low. It replaces only the granted source's word after each edge. This gives an alternating grant sequence and, at the same time, shows that the output has no bubble between words. A separate sequence fills the left buffer under stall and then offers a second word, which exercises the stall-and-hold path.

// File: rtl/tree_router_pkg.sv
package tree_router_pkg;
    typedef enum logic [1:0] {
        PORT_ROOT  = 2'd0,
        PORT_LEFT  = 2'd1,
        PORT_RIGHT = 2'd2
    } port_e;

    typedef enum logic {
        FAVOR_A = 1'b0,
        FAVOR_B = 1'b1
    } arb_state_e;

    typedef enum logic {
        EMPTY = 1'b0,
        FULL  = 1'b1
    } buf_state_e;
endpackage

// File: rtl/route_steer.sv
module route_steer
    import tree_router_pkg::*;
#(
    parameter int W       = 9,
    parameter int A       = 3,
    parameter int PORT_ID = 0
) (
    input  logic [W-1:0] word_in,
    output port_e        target,
    output logic [W-1:0] word_fwd
);
    logic dir_bit;
    assign dir_bit = word_in[W-1];

    generate
        if (A > 1) begin : g_rot
            assign word_fwd = {word_in[W-2:W-A], word_in[W-1], word_in[W-A-1:0]};
        end else begin : g_norot
            assign word_fwd = word_in;
        end

        if (PORT_ID == 0) begin : g_from_root
            assign target = dir_bit ? PORT_LEFT : PORT_RIGHT;
        end else if (PORT_ID == 1) begin : g_from_left
            assign target = dir_bit ? PORT_ROOT : PORT_RIGHT;
        end else begin : g_from_right
            assign target = dir_bit ? PORT_ROOT : PORT_LEFT;
        end
    endgenerate
endmodule

// File: rtl/merge_buf.sv
module merge_buf
    import tree_router_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_a,
    input  logic [W-1:0] data_a,
    input  logic         req_b,
    input  logic [W-1:0] data_b,
    output logic         grant_a,
    output logic         grant_b,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_stall
);
    arb_state_e arb_q, arb_d;
    buf_state_e buf_q, buf_d;
    logic [W-1:0] hold_q;
    logic ready;

    assign ready = (buf_q == EMPTY) || !out_stall;

    always_comb begin
        grant_a = 1'b0;
        grant_b = 1'b0;
        arb_d   = arb_q;
        unique case (arb_q)
            FAVOR_A: begin
                grant_a = ready && req_a;
                grant_b = ready && req_b && !req_a;
                if (ready && req_a && req_b) arb_d = FAVOR_B;
            end
            FAVOR_B: begin
                grant_b = ready && req_b;
                grant_a = ready && req_a && !req_b;
                if (ready && req_a && req_b) arb_d = FAVOR_A;
            end
            default: arb_d = FAVOR_A;
        endcase
    end

    always_comb begin
        buf_d = buf_q;
        unique case (buf_q)
            EMPTY:   if (grant_a || grant_b) buf_d = FULL;
            FULL:    if (!out_stall && !(grant_a || grant_b)) buf_d = EMPTY;
            default: buf_d = EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q  <= FAVOR_A;
            buf_q  <= EMPTY;
            hold_q <= '0;
        end else begin
            arb_q <= arb_d;
            buf_q <= buf_d;
            if (grant_a)      hold_q <= data_a;
            else if (grant_b) hold_q <= data_b;
        end
    end

    always_comb begin
        out_valid = (buf_q == FULL);
        out_data  = hold_q;
    end
endmodule

// File: rtl/tree_router.sv
module tree_router
    import tree_router_pkg::*;
#(
    parameter int W = 9,
    parameter int A = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          in_valid,
    input  logic [2:0][W-1:0]   in_data,
    output logic [2:0]          in_stall,
    output logic [2:0]          out_valid,
    output logic [2:0][W-1:0]   out_data,
    input  logic [2:0]          out_stall
);
    localparam int NP = 3;

    port_e             tgt   [NP];
    logic [NP-1:0][W-1:0] fwd;
    logic [NP-1:0][NP-1:0] gnt;

    generate
        for (genvar i = 0; i < NP; i++) begin : g_in
            route_steer #(.W(W), .A(A), .PORT_ID(i)) steer_i (
                .word_in (in_data[i]),
                .target  (tgt[i]),
                .word_fwd(fwd[i])
            );
        end

        for (genvar o = 0; o < NP; o++) begin : g_out
            localparam int SA = (o == 0) ? 1 : 0;
            localparam int SB = (o == 2) ? 1 : 2;
            logic ga, gb;
            merge_buf #(.W(W)) merge_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .req_a    (in_valid[SA] && (tgt[SA] == port_e'(o))),
                .data_a   (fwd[SA]),
                .req_b    (in_valid[SB] && (tgt[SB] == port_e'(o))),
                .data_b   (fwd[SB]),
                .grant_a  (ga),
                .grant_b  (gb),
                .out_valid(out_valid[o]),
                .out_data (out_data[o]),
                .out_stall(out_stall[o])
            );
            assign gnt[o][SA] = ga;
            assign gnt[o][SB] = gb;
            assign gnt[o][o]  = 1'b0;
        end

        for (genvar i = 0; i < NP; i++) begin : g_stall
            assign in_stall[i] = in_valid[i] && !(gnt[0][i] || gnt[1][i] || gnt[2][i]);
        end
    endgenerate
endmodule

// File: rtl/tree_router_chk.sv
module tree_router_chk #(
    parameter int W = 9,
    parameter int A = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        in_valid,
    input logic [2:0][W-1:0] in_data,
    input logic [2:0]        in_stall,
    input logic [2:0]        out_valid,
    input logic [2:0][W-1:0] out_data,
    input logic [2:0]        out_stall
);
    function automatic logic [W-1:0] rot(input logic [W-1:0] w);
        return {w[W-2:W-A], w[W-1], w[W-A-1:0]};
    endfunction

    generate
        for (genvar k = 0; k < 3; k++) begin : g_k
            // R6
            hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid[k] && out_stall[k]) |=> (out_valid[k] && $stable(out_data[k])));
            // R1
            stall_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid[k] |-> !in_stall[k]);
        end
    endgenerate

    // R2
    root_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[0] && !in_stall[0] && in_data[0][W-1]) |=>
        (out_valid[1] && out_data[1] == rot($past(in_data[0]))));

    // R2
    root_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[0] && !in_stall[0] && !in_data[0][W-1]) |=>
        (out_valid[2] && out_data[2] == rot($past(in_data[0]))));

    // R3
    left_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[1] && !in_stall[1] && in_data[1][W-1]) |=>
        (out_valid[0] && out_data[0] == rot($past(in_data[1]))));

    // R3
    right_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[2] && !in_stall[2] && in_data[2][W-1]) |=>
        (out_valid[0] && out_data[0] == rot($past(in_data[2]))));
endmodule

bind tree_router tree_router_chk #(.W(W), .A(A)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_stall (in_stall),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_stall(out_stall)
);

// File: tb/tree_router_tb_top.sv
module tree_router_tb_top;
    localparam int W = 9;
    localparam int A = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        in_valid = '0;
    logic [2:0][W-1:0] in_data = '0;
    logic [2:0]        in_stall;
    logic [2:0]        out_valid;
    logic [2:0][W-1:0] out_data;
    logic [2:0]        out_stall = '0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tree_router #(.W(W), .A(A)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_stall(in_stall),
        .out_valid(out_valid), .out_data(out_data), .out_stall(out_stall)
    );

    function automatic logic [W-1:0] mk(input logic [2:0] ad, input logic [5:0] pl);
        return {ad, pl};
    endfunction

    function automatic logic [W-1:0] exp_rot(input logic [W-1:0] w);
        return {w[W-2:W-A], w[W-1], w[W-A-1:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(out_valid == 3'b000, "R1 out_valid", 32'(out_valid), 0);
        chk(in_stall == 3'b000, "R1 in_stall", 32'(in_stall), 0);
    endtask

    task automatic t_root_route();
        logic [W-1:0] w;
        w = mk(3'b101, 6'h2A);
        in_valid[0] = 1; in_data[0] = w;
        #1 chk(in_stall[0] == 0, "R2 root accept", 32'(in_stall[0]), 0);
        @(negedge clk);
        in_valid[0] = 0;
        chk(out_valid[1] == 1 && out_valid[2] == 0, "R2/R5 left valid", 32'(out_valid), 3'b010);
        chk(out_data[1] == exp_rot(w), "R4 rotate left", 32'(out_data[1]), 32'(exp_rot(w)));
        w = mk(3'b010, 6'h15);
        in_valid[0] = 1; in_data[0] = w;
        @(negedge clk);
        in_valid[0] = 0;
        chk(out_valid[2] == 1 && out_valid[1] == 0, "R2 right valid", 32'(out_valid), 3'b100);
        chk(out_data[2] == mk(3'b100, 6'h15), "R4 rotate right", 32'(out_data[2]), 32'(mk(3'b100, 6'h15)));
        @(negedge clk);
        chk(out_valid == 3'b000, "R5 drained", 32'(out_valid), 0);
    endtask

    task automatic t_child_route();
        logic [W-1:0] wl, wr;
        wl = mk(3'b110, 6'h01);
        wr = mk(3'b011, 6'h3C);
        in_valid[1] = 1; in_data[1] = wl;
        in_valid[2] = 1; in_data[2] = wr;
        #1 chk(in_stall[2:1] == 2'b00, "R10 both accepted", 32'(in_stall), 0);
        @(negedge clk);
        in_valid = '0;
        chk(out_valid == 3'b011, "R3/R10 up and left", 32'(out_valid), 3'b011);
        chk(out_data[0] == exp_rot(wl), "R3 left to root", 32'(out_data[0]), 32'(exp_rot(wl)));
        chk(out_data[1] == exp_rot(wr), "R3 right to left", 32'(out_data[1]), 32'(exp_rot(wr)));
        wl = mk(3'b001, 6'h0F);
        in_valid[1] = 1; in_data[1] = wl;
        @(negedge clk);
        in_valid = '0;
        chk(out_valid[2] == 1 && out_data[2] == exp_rot(wl), "R3 left to right", 32'(out_data[2]), 32'(exp_rot(wl)));
        @(negedge clk);
    endtask

    task automatic t_hold();
        logic [W-1:0] w1, w2;
        w1 = mk(3'b100, 6'h11);
        w2 = mk(3'b111, 6'h22);
        out_stall[1] = 1;
        in_valid[0] = 1; in_data[0] = w1;
        @(negedge clk);
        in_data[0] = w2;
        #1 chk(in_stall[0] == 1, "R7 stall asserted", 32'(in_stall[0]), 1);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk(out_valid[1] == 1 && out_data[1] == exp_rot(w1), "R6 held while stalled",
                32'(out_data[1]), 32'(exp_rot(w1)));
        end
        out_stall[1] = 0;
        #1 chk(in_stall[0] == 0, "R7 stall released", 32'(in_stall[0]), 0);
        @(negedge clk);
        in_valid[0] = 0;
        chk(out_valid[1] == 1 && out_data[1] == exp_rot(w2), "R7 second word delivered",
            32'(out_data[1]), 32'(exp_rot(w2)));
        @(negedge clk);
        chk(out_valid[1] == 0, "R7 no duplicate", 32'(out_valid[1]), 0);
    endtask

    task automatic t_round_robin();
        logic [W-1:0] a0, a1, b0, b1;
        a0 = mk(3'b100, 6'h0A); a1 = mk(3'b101, 6'h1A);
        b0 = mk(3'b110, 6'h0B); b1 = mk(3'b111, 6'h1B);
        in_valid[1] = 1; in_data[1] = a0;
        in_valid[2] = 1; in_data[2] = b0;
        #1 chk(in_stall[2:1] == 2'b10, "R8 lower index first", 32'(in_stall), 3'b100);
        @(negedge clk);
        chk(out_data[0] == exp_rot(a0), "R8 first winner", 32'(out_data[0]), 32'(exp_rot(a0)));
        in_data[1] = a1;
        #1 chk(in_stall[2:1] == 2'b01, "R8 grant alternates", 32'(in_stall), 3'b010);
        @(negedge clk);
        chk(out_valid[0] == 1 && out_data[0] == exp_rot(b0), "R9 no bubble", 32'(out_data[0]), 32'(exp_rot(b0)));
        in_data[2] = b1;
        #1 chk(in_stall[2:1] == 2'b10, "R8 grant back", 32'(in_stall), 3'b100);
        @(negedge clk);
        chk(out_valid[0] == 1 && out_data[0] == exp_rot(a1), "R9 third word", 32'(out_data[0]), 32'(exp_rot(a1)));
        in_valid[1] = 0;
        @(negedge clk);
        in_valid[2] = 0;
        chk(out_valid[0] == 1 && out_data[0] == exp_rot(b1), "R9 fourth word", 32'(out_data[0]), 32'(exp_rot(b1)));
        @(negedge clk);
        chk(out_valid[0] == 0, "R9 drained", 32'(out_valid[0]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_root_route();
        t_child_route();
        t_hold();
        t_round_robin();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule